// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a card-to-reader frame in which each bit is a fixed-length time slot that either carries a subcarrier (logic 1) or stays quiet (logic 0). The reader pulses `start_i` at the moment its own frame ends. The block then waits a fixed gap and walks through the requested number of slots. In each slot it counts every level change of the sliced, synchronized subcarrier input. It turns that count into one bit by checking it against a window.

The card frame has no start or stop marker and no length field, so the caller supplies the bit count. A frame of all zeros looks exactly like an absent card, and no presence indication is produced. When decryption is requested, the assembled word is XORed with a keystream word that the caller prepared before reception. The block reports the word with a one-cycle done pulse. Its slot timebase restarts from every start strobe, so consecutive frames stay aligned to the reader.

Top module: `subcar_edge_demod`

## Requirements
- R1: After reset, `done_o` is 0 and `data_o` is 0.
- R2: With a tick of TICK_DIV clocks, the first slot starts GAP_TICKS ticks after the clock edge that samples `start_i`. Every slot lasts SLOT_TICKS ticks. `done_o` is high for exactly one cycle, registered (GAP_TICKS + n*SLOT_TICKS)*TICK_DIV clocks after that edge, where n is the effective bit count. `data_o` changes only on that cycle or on the cycle after a start strobe.
- R3: A slot whose edge count is strictly above LO_EDGES (20) and strictly below HI_EDGES (60) decodes as 1. Any other count, including exactly 20 and exactly 60, decodes as 0.
- R4: The first slot's bit is placed in `data_o[0]`, and slot k's bit in `data_o[k]`. Bits at or above the effective count read 0 when decryption is off.
- R5: The bit count `len_i` is 6 bits wide. Values above 32 are clamped to 32, which gives 32 slots and matching done timing.
- R6: With `decrypt_i` = 1, `data_o` is the decoded word XOR (`key_i` with only its low n bits kept). With `decrypt_i` = 0, `key_i` has no effect.
- R7: The per-slot edge counter saturates at its all-ones value and does not wrap. A slot with more edges than the counter can hold therefore decodes as 0.
- R8: `len_i`, `decrypt_i` and `key_i` are captured on the start strobe. Later changes during reception do not affect the result.
- R9: A start strobe during reception abandons the frame in progress without a done pulse and begins a new frame.
- R10: A bit count of 0 gives a done pulse right after the gap, with `data_o` = 0, even when decryption is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe marking the end of the reader frame |
| len_i | input | 6 | Requested number of bits, clamped to MAX_BITS |
| decrypt_i | input | 1 | Apply keystream XOR to the result |
| key_i | input | MAX_BITS | Precomputed keystream word, LSB for the first slot |
| din_i | input | 1 | Sliced subcarrier signal, asynchronous |
| data_o | output | MAX_BITS | Received word, LSB first |
| done_o | output | 1 | One-cycle pulse when `data_o` is valid |

## Verification
Directed frames place edge counts of 19, 20, 21, 42, 59, 60 and 61 in known slots. These show whether the window bounds are strict, and a lone 1 in a middle slot shows the bit order. Counts above the counter's capacity separate a saturating counter from a wrapping one, because a wrapped count would land inside the window. Further frames vary the length (0, short, exactly 32, above 32), the decrypt flag with a non-zero key, and changes to the captured inputs or a restart during reception. Random frames then mix all count classes with random lengths and keys. Each frame checks the exact done cycle as well as the word.

// File: rtl/sed_pkg.sv
package sed_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_SLOT = 2'd2
    } phase_e;

endpackage

// File: rtl/sed_sync.sv
module sed_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic edge_o
);
    typedef struct packed {
        logic [1:0] ff;
        logic       prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ff   = {st_q.ff[0], din_i};
        st_d.prev = st_q.ff[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign edge_o = st_q.ff[1] ^ st_q.prev;
endmodule

// File: rtl/sed_tick.sv
module sed_tick #(
    parameter int TICK_DIV = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DW = $clog2(TICK_DIV);

    logic [DW-1:0] div_d, div_q;
    logic          wrap;

    assign wrap = (div_q == DW'(TICK_DIV - 1));

    always_comb begin
        if (clr_i || wrap) div_d = '0;
        else               div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assign tick_o = wrap && !clr_i;
endmodule

// File: rtl/sed_edge_cnt.sv
module sed_edge_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                      cnt_d = '0;
        else if (inc_i && !(&cnt_q))    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/subcar_edge_demod.sv
module subcar_edge_demod
    import sed_pkg::*;
#(
    parameter int TICK_DIV   = 32,
    parameter int GAP_TICKS  = 490,
    parameter int SLOT_TICKS = 150,
    parameter int LO_EDGES   = 20,
    parameter int HI_EDGES   = 60,
    parameter int MAX_BITS   = 32,
    parameter int CNT_W      = 8,
    localparam int IW        = $clog2(MAX_BITS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [IW-1:0]       len_i,
    input  logic                decrypt_i,
    input  logic [MAX_BITS-1:0] key_i,
    input  logic                din_i,
    output logic [MAX_BITS-1:0] data_o,
    output logic                done_o
);
    localparam int SPAN = (GAP_TICKS > SLOT_TICKS) ? GAP_TICKS : SLOT_TICKS;
    localparam int TW   = $clog2(SPAN);

    typedef struct packed {
        phase_e              phase;
        logic [TW-1:0]       tick_cnt;
        logic [IW-1:0]       bit_idx;
        logic [IW-1:0]       nbits;
        logic                dec;
        logic [MAX_BITS-1:0] key;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] data;
        logic                done;
    } state_t;

    state_t st_d, st_q;

    logic             edge_pulse;
    logic             tick;
    logic             tick_clr;
    logic             cnt_clr;
    logic             slot_end;
    logic [CNT_W-1:0] edge_cnt;
    logic             slot_bit;
    logic [MAX_BITS-1:0] key_mask;
    logic [MAX_BITS-1:0] acc_next;

    sed_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (din_i),
        .edge_o (edge_pulse)
    );

    assign tick_clr = start_i || (st_q.phase == PH_IDLE);

    sed_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    assign slot_end = (st_q.phase == PH_SLOT) && tick &&
                      (st_q.tick_cnt == TW'(SLOT_TICKS - 1));
    assign cnt_clr  = start_i || slot_end || (st_q.phase != PH_SLOT);

    sed_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .inc_i  (edge_pulse && (st_q.phase == PH_SLOT)),
        .cnt_o  (edge_cnt)
    );

    // Window decision on the count gathered over the slot
    assign slot_bit = (edge_cnt > CNT_W'(LO_EDGES)) && (edge_cnt < CNT_W'(HI_EDGES));

    always_comb begin
        for (int i = 0; i < MAX_BITS; i++) begin
            key_mask[i] = (i < int'(st_q.nbits));
            acc_next[i] = (i == int'(st_q.bit_idx)) ? slot_bit : st_q.acc[i];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.phase    = PH_GAP;
            st_d.tick_cnt = '0;
            st_d.bit_idx  = '0;
            st_d.nbits    = (len_i > IW'(MAX_BITS)) ? IW'(MAX_BITS) : len_i;
            st_d.dec      = decrypt_i;
            st_d.key      = key_i;
            st_d.acc      = '0;
            st_d.data     = '0;
        end else begin
            unique case (st_q.phase)
                PH_GAP: begin
                    if (tick) begin
                        if (st_q.tick_cnt == TW'(GAP_TICKS - 1)) begin
                            st_d.tick_cnt = '0;
                            if (st_q.nbits == '0) begin
                                st_d.phase = PH_IDLE;
                                st_d.data  = '0;
                                st_d.done  = 1'b1;
                            end else begin
                                st_d.phase = PH_SLOT;
                            end
                        end else begin
                            st_d.tick_cnt = st_q.tick_cnt + 1'b1;
                        end
                    end
                end
                PH_SLOT: begin
                    if (tick) begin
                        if (slot_end) begin
                            st_d.tick_cnt = '0;
                            st_d.acc      = acc_next;
                            st_d.bit_idx  = st_q.bit_idx + 1'b1;
                            if (st_q.bit_idx + 1'b1 == st_q.nbits) begin
                                st_d.phase = PH_IDLE;
                                st_d.data  = acc_next ^ (st_q.dec ? (st_q.key & key_mask) : '0);
                                st_d.done  = 1'b1;
                            end
                        end else begin
                            st_d.tick_cnt = st_q.tick_cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_IDLE, default: '0};
        else         st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign done_o = st_q.done;
endmodule

// File: rtl/subcar_edge_demod_chk.sv
module subcar_edge_demod_chk #(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = 8,
    parameter int IW       = 6
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic                done_o,
    input logic [MAX_BITS-1:0] data_o,
    input logic [CNT_W-1:0]    edge_cnt,
    input logic                cnt_clr,
    input logic [IW-1:0]       bit_idx
);
    // R2: done lasts a single cycle
    p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R2: result word moves only with done or after a start strobe
    p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> (done_o || $stable(data_o)));

    // R7: a full edge counter stays full until cleared
    p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&edge_cnt) && !cnt_clr) |=> (&edge_cnt));

    // R5: slot index never runs past the clamped length
    p_len_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_idx <= IW'(MAX_BITS));
endmodule

bind subcar_edge_demod subcar_edge_demod_chk #(
    .MAX_BITS (MAX_BITS),
    .CNT_W    (CNT_W),
    .IW       (IW)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .done_o   (done_o),
    .data_o   (data_o),
    .edge_cnt (edge_cnt),
    .cnt_clr  (cnt_clr),
    .bit_idx  (st_q.bit_idx)
);

// File: tb/subcar_edge_demod_bench.sv
module subcar_edge_demod_bench;
    localparam int TD    = 2;
    localparam int GAP   = 10;
    localparam int SLOT  = 60;
    localparam int CW    = 6;
    localparam int NB    = 32;
    localparam int LW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len = '0;
    logic          dec = 1'b0;
    logic [NB-1:0] key = '0;
    logic          din = 1'b0;
    logic [NB-1:0] data;
    logic          done;

    int errors = 0;
    int checks = 0;
    int slot_n [NB];

    always #4 clk = ~clk;

    subcar_edge_demod #(
        .TICK_DIV(TD), .GAP_TICKS(GAP), .SLOT_TICKS(SLOT),
        .LO_EDGES(20), .HI_EDGES(60), .MAX_BITS(NB), .CNT_W(CW)
    ) u_subcar_edge_demod (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
        .decrypt_i(dec), .key_i(key), .din_i(din), .data_o(data), .done_o(done)
    );

    function automatic int eff_len(int l);
        return (l > NB) ? NB : l;
    endfunction

    function automatic logic [NB-1:0] expect_word(int l, bit d, logic [NB-1:0] k);
        logic [NB-1:0] w = '0;
        int n = eff_len(l);
        for (int i = 0; i < n; i++) begin
            int c = (slot_n[i] > 63) ? 63 : slot_n[i];
            w[i] = (c > 20) && (c < 60);
            if (d) w[i] = w[i] ^ k[i];
        end
        return w;
    endfunction

    task automatic check(bit ok, string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one frame; abort_at > 0 stops early (for restart). scramble changes
    // captured inputs after the strobe.
    task automatic run_frame(int l, bit d, logic [NB-1:0] k, string tag,
                             int abort_at, bit scramble);
        int n = eff_len(l);
        int fin = (GAP + n * SLOT) * TD;
        logic [NB-1:0] exp = expect_word(l, d, k);
        bit timing_ok = 1'b1;
        bit seen = 1'b0;
        logic [NB-1:0] got = '0;
        start = 1'b1; len = LW'(l); dec = d; key = k;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            len = LW'(l + 7); dec = ~d; key = ~k;
        end
        for (int c = 1; c <= fin + 2; c++) begin
            int rel = c - GAP * TD;
            if (abort_at > 0 && c == abort_at) return;
            if (rel > 0 && n > 0) begin
                int s = (rel - 1) / (SLOT * TD);
                int off = rel - s * SLOT * TD;
                if (s < n && off >= 5 && off < 5 + slot_n[s]) din = ~din;
            end
            if (done !== (c == fin + 1)) timing_ok = 1'b0;
            if (done === 1'b1 && c == fin + 1) begin seen = 1'b1; got = data; end
            @(negedge clk);
        end
        check(timing_ok && seen, {tag, " R2 done timing"}, {31'd0, seen}, 32'd1);
        check(got === exp, tag, got, exp);
    endtask

    task automatic fill(int v);
        for (int i = 0; i < NB; i++) slot_n[i] = v;
    endtask

    initial begin
        #1_520_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(done === 1'b0 && data === '0, "R1 reset", data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        fill(42);
        run_frame(32, 1'b0, '0, "R4 all ones", 0, 1'b0);

        fill(0);
        slot_n[0] = 20; slot_n[1] = 21; slot_n[2] = 59; slot_n[3] = 60;
        slot_n[4] = 19; slot_n[5] = 42; slot_n[6] = 61; slot_n[7] = 0;
        run_frame(8, 1'b0, '0, "R3 window bounds", 0, 1'b0);

        fill(0);
        slot_n[0] = 100; slot_n[1] = 70; slot_n[2] = 42; slot_n[3] = 90;
        run_frame(4, 1'b0, '0, "R7 saturation", 0, 1'b0);

        fill(0);
        slot_n[5] = 40;
        run_frame(12, 1'b0, '0, "R4 lsb first", 0, 1'b0);

        fill(30);
        run_frame(40, 1'b0, '0, "R5 clamp", 0, 1'b0);

        fill(0);
        slot_n[1] = 42; slot_n[2] = 42;
        run_frame(12, 1'b1, 32'hFFFF_FFFF, "R6 decrypt masked", 0, 1'b0);
        run_frame(12, 1'b0, 32'hA5A5_5A5A, "R6 key ignored", 0, 1'b0);

        run_frame(0, 1'b1, 32'hFFFF_FFFF, "R10 zero length", 0, 1'b0);

        slot_n[0] = 42; slot_n[3] = 50;
        run_frame(6, 1'b1, 32'h0000_0015, "R8 captured inputs", 0, 1'b1);

        fill(42);
        run_frame(10, 1'b0, '0, "R9 aborted", 300, 1'b0);
        fill(0);
        slot_n[2] = 33;
        run_frame(5, 1'b0, '0, "R9 restart", 0, 1'b0);

        for (int f = 0; f < 18; f++) begin
            int l = int'($urandom_range(1, 32));
            bit d = 1'($urandom_range(0, 1));
            logic [NB-1:0] k = $urandom;
            for (int i = 0; i < NB; i++) begin
                case ($urandom_range(0, 3))
                    0: slot_n[i] = int'($urandom_range(0, 20));
                    1: slot_n[i] = int'($urandom_range(21, 59));
                    2: slot_n[i] = int'($urandom_range(60, 100));
                    default: slot_n[i] = 42;
                endcase
            end
            run_frame(l, d, k, "R3 R6 random", 0, 1'b0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule